// File: doc/BRIEF.md
# Two-Bank Floating-Point Register File

This block holds thirty-two 32-bit words, organised as two banks of sixteen. A single mode input decides which bank is the current bank; the other bank is the extended bank. Every access names a register by an index and a bank select. The select picks either the current bank or the extended bank. The same storage can be seen as single words, as aligned 64-bit pairs, or, for reads of the current bank only, as aligned 128-bit quads.

There is one write port. It writes either a single word or an aligned pair. There are two independent read ports with combinational data. Flipping the mode input exchanges the roles of the two banks at once, and no stored data moves. Arithmetic, status handling and exceptions are not part of the block. It only provides the naming, the mapping and the storage.

Top module: `fpr_bank_file`

## Requirements
- R1: An active-high synchronous reset clears all 32 words to zero. After reset, every read of any kind returns zero.
- R2: A single-word access (kind 2'b00) with extended select 0 reaches physical bank `bank_mode`, word `idx`.
- R3: A single-word access with extended select 1 reaches the other bank, physical bank `!bank_mode`, word `idx`.
- R4: Read data is right-aligned in the 128-bit bus, and unused upper bits are zero. A single read returns the word in bits [31:0]. A pair read (kind 2'b01) returns word n in bits [63:32] and word n+1 in bits [31:0].
- R5: A quad read (kind 2'b10) returns words n..n+3 of the current bank, with word n in bits [127:96] and word n+3 in bits [31:0]. The extended select and the two low index bits are ignored.
- R6: A pair write updates both words at the same clock edge: wr_data[63:32] goes to word n and wr_data[31:0] goes to word n+1. For pair accesses, bit 0 of the index is ignored. This holds for reads as well as writes.
- R7: Writes of kind 2'b10 or 2'b11 change no stored word. A read of kind 2'b11 returns zero.
- R8: A change of `bank_mode` affects the very next read combinationally, and no stored data moves. An extended-bank name under one mode reads the same word as the current-bank name under the other mode.
- R9: If a read and a write target the same word in the same cycle, the read returns the value held before the clock edge.
- R10: The two read ports operate independently and at the same time, each with its own kind, select and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all words |
| bank_mode | input | 1 | Chooses the current bank (0: bank 0 current, 1: bank 1 current) |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write kind: 00 single, 01 pair, others ignored |
| wr_ext | input | 1 | Write bank select: 0 current, 1 extended |
| wr_idx | input | 4 | Write word index within the bank |
| wr_data | input | 64 | Write data; single uses [31:0] |
| rd0_kind | input | 2 | Read port 0 kind: 00 single, 01 pair, 10 quad, 11 none |
| rd0_ext | input | 1 | Read port 0 bank select |
| rd0_idx | input | 4 | Read port 0 word index |
| rd0_data | output | 128 | Read port 0 data, right-aligned |
| rd1_kind | input | 2 | Read port 1 kind |
| rd1_ext | input | 1 | Read port 1 bank select |
| rd1_idx | input | 4 | Read port 1 word index |
| rd1_data | output | 128 | Read port 1 data, right-aligned |

## Verification
The hardest situation to reach from the ports is a read and a write that land on the same physical word in one cycle while the mode input is also being used to alias names. The old value is visible only in the short window before the edge. To reach it, the stimulus raises the write strobe at the falling edge, samples the read port before the rising edge, and samples it again just after. The bank aliasing is covered by a full sweep. For every index, select, kind and both mode values, the read is compared against a 32-word reference that is loaded by random single and pair writes. The sweep includes odd and unaligned indices.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    ACC_ONE  = 2'b00,
    ACC_PAIR = 2'b01,
    ACC_QUAD = 2'b10,
    ACC_NONE = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/fpr_addr_map.sv
// Turns a (mode, select, kind, index) name into an aligned physical word index.
module fpr_addr_map #(
  parameter int RPB = 16,
  localparam int IW = $clog2(RPB),
  localparam int AW = IW + 1
) (
  input  logic          bank_mode,
  input  logic          ext_sel,
  input  logic [1:0]    kind,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] base
);
  import fpr_pkg::*;

  logic          bank;
  logic [IW-1:0] aligned;

  always_comb begin
    bank    = bank_mode ^ ext_sel;
    aligned = idx;
    case (acc_kind_e'(kind))
      ACC_PAIR: aligned[0] = 1'b0;
      ACC_QUAD: begin
        aligned[1:0] = 2'b00;
        bank         = bank_mode;
      end
      default: ;
    endcase
    base = {bank, aligned};
  end
endmodule

// File: rtl/fpr_regs.sv
// Word storage with two write lanes so a pair lands in one edge.
module fpr_regs #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wd_b,
  output logic [DW-1:0] words [NREG]
);
  for (genvar i = 0; i < NREG; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[i] <= '0;
      else if (we_a && addr_a == AW'(i))
        words[i] <= wd_a;
      else if (we_b && addr_b == AW'(i))
        words[i] <= wd_b;
    end
  end
endmodule

// File: rtl/fpr_read_gather.sv
// Assembles a right-aligned read word from up to four stored words.
module fpr_read_gather #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int RW  = 4 * DW
) (
  input  logic [DW-1:0] words [NREG],
  input  logic [AW-1:0] base,
  input  logic [1:0]    kind,
  output logic [RW-1:0] data
);
  import fpr_pkg::*;

  logic [DW-1:0] lane [4];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane[k] = words[base | AW'(k)];
  end

  always_comb begin
    data = '0;
    case (acc_kind_e'(kind))
      ACC_ONE:  data[DW-1:0]   = lane[0];
      ACC_PAIR: data[2*DW-1:0] = {lane[0], lane[1]};
      ACC_QUAD: data           = {lane[0], lane[1], lane[2], lane[3]};
      default:  data           = '0;
    endcase
  end
endmodule

// File: rtl/fpr_bank_file.sv
module fpr_bank_file #(
  parameter int DW  = 32,
  parameter int RPB = 16,
  localparam int IW = $clog2(RPB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bank_mode,
  input  logic            wr_en,
  input  logic [1:0]      wr_kind,
  input  logic            wr_ext,
  input  logic [IW-1:0]   wr_idx,
  input  logic [2*DW-1:0] wr_data,
  input  logic [1:0]      rd0_kind,
  input  logic            rd0_ext,
  input  logic [IW-1:0]   rd0_idx,
  output logic [4*DW-1:0] rd0_data,
  input  logic [1:0]      rd1_kind,
  input  logic            rd1_ext,
  input  logic [IW-1:0]   rd1_idx,
  output logic [4*DW-1:0] rd1_data
);
  import fpr_pkg::*;

  localparam int NREG = 2 * RPB;
  localparam int AW   = IW + 1;
  localparam int NRD  = 2;

  logic [DW-1:0] words [NREG];
  logic [AW-1:0] wr_base;
  logic          we_a, we_b;
  logic [DW-1:0] wd_a;

  fpr_addr_map #(.RPB(RPB)) wr_map_i (
    .bank_mode (bank_mode),
    .ext_sel   (wr_ext),
    .kind      (wr_kind),
    .idx       (wr_idx),
    .base      (wr_base)
  );

  always_comb begin
    we_a = wr_en && (wr_kind == ACC_ONE || wr_kind == ACC_PAIR);
    we_b = wr_en && (wr_kind == ACC_PAIR);
    wd_a = (wr_kind == ACC_PAIR) ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
  end

  fpr_regs #(.DW(DW), .NREG(NREG)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .we_a   (we_a),
    .addr_a (wr_base),
    .wd_a   (wd_a),
    .we_b   (we_b),
    .addr_b (wr_base | AW'(1)),
    .wd_b   (wr_data[DW-1:0]),
    .words  (words)
  );

  logic [1:0]      rk   [NRD];
  logic            rx   [NRD];
  logic [IW-1:0]   ri   [NRD];
  logic [4*DW-1:0] rdat [NRD];

  assign rk[0] = rd0_kind;
  assign rx[0] = rd0_ext;
  assign ri[0] = rd0_idx;
  assign rk[1] = rd1_kind;
  assign rx[1] = rd1_ext;
  assign ri[1] = rd1_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [AW-1:0] base;

    fpr_addr_map #(.RPB(RPB)) map_i (
      .bank_mode (bank_mode),
      .ext_sel   (rx[p]),
      .kind      (rk[p]),
      .idx       (ri[p]),
      .base      (base)
    );

    fpr_read_gather #(.DW(DW), .NREG(NREG)) gather_i (
      .words (words),
      .base  (base),
      .kind  (rk[p]),
      .data  (rdat[p])
    );
  end

  assign rd0_data = rdat[0];
  assign rd1_data = rdat[1];
endmodule

// File: rtl/fpr_bank_file_chk.sv
module fpr_bank_file_chk #(
  parameter int DW  = 32,
  parameter int RPB = 16,
  localparam int IW = $clog2(RPB)
) (
  input logic            clk,
  input logic            rst,
  input logic            bank_mode,
  input logic            wr_en,
  input logic [1:0]      wr_kind,
  input logic            wr_ext,
  input logic [IW-1:0]   wr_idx,
  input logic [2*DW-1:0] wr_data,
  input logic [1:0]      rd0_kind,
  input logic            rd0_ext,
  input logic [IW-1:0]   rd0_idx,
  input logic [4*DW-1:0] rd0_data,
  input logic [1:0]      rd1_kind,
  input logic            rd1_ext,
  input logic [IW-1:0]   rd1_idx,
  input logic [4*DW-1:0] rd1_data
);
  // R1: the cycle after a reset edge, both ports read zero
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd0_data == '0 && rd1_data == '0));

  // R2, R3: a single write is visible through the matching physical name
  a_r3_single_roundtrip: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_kind == 2'b00 && !rst) && rd0_kind == 2'b00 &&
     {bank_mode ^ rd0_ext, rd0_idx} == $past({bank_mode ^ wr_ext, wr_idx}))
    |-> rd0_data[DW-1:0] == $past(wr_data[DW-1:0]));

  // R6: a pair write lands in both words at one edge
  a_r6_pair_roundtrip: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && wr_kind == 2'b01 && !rst) && rd0_kind == 2'b01 &&
     {bank_mode ^ rd0_ext, rd0_idx[IW-1:1]} ==
       $past({bank_mode ^ wr_ext, wr_idx[IW-1:1]}))
    |-> rd0_data[2*DW-1:0] == $past(wr_data));

  // R4: unused upper bits are zero
  a_r4_single_upper: assert property (@(posedge clk) disable iff (rst)
    rd1_kind == 2'b00 |-> rd1_data[4*DW-1:DW] == '0);
  a_r4_pair_upper: assert property (@(posedge clk) disable iff (rst)
    rd1_kind == 2'b01 |-> rd1_data[4*DW-1:2*DW] == '0);

  // R7: the unused read kind returns zero
  a_r7_none_zero: assert property (@(posedge clk) disable iff (rst)
    rd0_kind == 2'b11 |-> rd0_data == '0);

  // R8: flipping mode and select together reads the same word
  a_r8_swap_alias: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst) && bank_mode != $past(bank_mode) &&
     rd0_ext != $past(rd0_ext) && rd0_kind == $past(rd0_kind) &&
     rd0_kind != 2'b10 && rd0_idx == $past(rd0_idx))
    |-> rd0_data == $past(rd0_data));
endmodule

bind fpr_bank_file fpr_bank_file_chk #(.DW(DW), .RPB(RPB)) chk_i (.*);

// File: tb/fpr_bank_file_tb_top.sv
module fpr_bank_file_tb_top;
  localparam int DW = 32;
  localparam int RPB = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1, bank_mode = 1'b0, wr_en = 1'b0, wr_ext = 1'b0;
  logic [1:0]   wr_kind = 2'b00;
  logic [3:0]   wr_idx = '0;
  logic [63:0]  wr_data = '0;
  logic [1:0]   rd0_kind = 2'b00, rd1_kind = 2'b00;
  logic         rd0_ext = 1'b0, rd1_ext = 1'b0;
  logic [3:0]   rd0_idx = '0, rd1_idx = '0;
  logic [127:0] rd0_data, rd1_data;

  fpr_bank_file #(.DW(DW), .RPB(RPB)) dut_i (.*);

  logic [31:0] refm [32];
  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {int port; logic [127:0] exp; string tag;} item_t;
  item_t sb[$];
  event go;

  function automatic logic [127:0] model(logic [1:0] k, logic e, logic [3:0] i);
    int b;
    logic [3:0] a;
    case (k)
      2'b00: begin b = 16 * int'(bank_mode ^ e); return {96'h0, refm[b + i]}; end
      2'b01: begin
        b = 16 * int'(bank_mode ^ e); a = i & 4'he;
        return {64'h0, refm[b + a], refm[b + a + 1]};
      end
      2'b10: begin
        b = 16 * int'(bank_mode); a = i & 4'hc;
        return {refm[b + a], refm[b + a + 1], refm[b + a + 2], refm[b + a + 3]};
      end
      default: return '0;
    endcase
  endfunction

  task automatic push_rd(int port, logic [1:0] k, logic e, logic [3:0] i, string tag);
    if (port == 0) begin rd0_kind = k; rd0_ext = e; rd0_idx = i; end
    else begin rd1_kind = k; rd1_ext = e; rd1_idx = i; end
    sb.push_back('{port, model(k, e, i), tag});
  endtask

  task automatic fire();
    -> go;
    #2;
  endtask

  task automatic chk_read(int port, logic [1:0] k, logic e, logic [3:0] i, string tag);
    push_rd(port, k, e, i, tag);
    fire();
  endtask

  // monitor: pops expected items and compares once outputs settle
  initial forever begin
    @(go);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [127:0] act;
      it = sb.pop_front();
      act = (it.port == 0) ? rd0_data : rd1_data;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s port%0d: got %h expected %h", it.tag, it.port, act, it.exp);
      end
    end
  end

  task automatic do_write(logic [1:0] k, logic e, logic [3:0] i, logic [63:0] d);
    logic [3:0] a;
    int b;
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_ext = e; wr_idx = i; wr_data = d;
    @(posedge clk);
    b = 16 * int'(bank_mode ^ e);
    if (k == 2'b00) refm[b + i] = d[31:0];
    else if (k == 2'b01) begin
      a = i & 4'he;
      refm[b + a] = d[63:32];
      refm[b + a + 1] = d[31:0];
    end
    #1 wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    foreach (refm[j]) refm[j] = '0;
  endtask

  task automatic sweep(string tag);
    for (int m = 0; m < 2; m++) begin
      bank_mode = m[0];
      for (int i = 0; i < 16; i++) begin
        for (int e = 0; e < 2; e++) begin
          push_rd(0, 2'b00, e[0], i[3:0], e ? "R3 ext single" : "R2 cur single");
          push_rd(1, 2'b01, e[0], i[3:0], "R4/R6 pair");
          fire();
          push_rd(0, 2'b10, e[0], i[3:0], "R5 quad");
          push_rd(1, 2'b11, e[0], i[3:0], "R7 none read");
          fire();
        end
      end
    end
    $display("sweep done: %s", tag);
  endtask

  initial begin
    foreach (refm[j]) refm[j] = '0;
    do_reset();
    // R1: reset state
    chk_read(0, 2'b10, 1'b0, 4'd0, "R1 reset quad");
    chk_read(1, 2'b01, 1'b1, 4'd6, "R1 reset pair");
    // random single and pair writes under both modes
    for (int n = 0; n < 60; n++) begin
      bank_mode = $urandom_range(0, 1);
      do_write(2'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               4'($urandom_range(0, 15)), {$urandom, $urandom});
    end
    // R7: vector-kind and unused-kind writes change nothing
    do_write(2'b10, 1'b0, 4'd4, 64'hdead_beef_0bad_f00d);
    do_write(2'b11, 1'b1, 4'd9, 64'h1234_5678_9abc_def0);
    sweep("random fill");
    // R6: odd index pair write lands on aligned pair
    bank_mode = 1'b0;
    do_write(2'b01, 1'b1, 4'd7, 64'haaaa_0001_bbbb_0002);
    chk_read(0, 2'b00, 1'b1, 4'd6, "R6 pair hi word");
    chk_read(0, 2'b00, 1'b1, 4'd7, "R6 pair lo word");
    // R8: mode flip aliases extended and current names
    do_write(2'b00, 1'b0, 4'd5, 64'h0000_0000_5a5a_0005);
    bank_mode = 1'b1;
    chk_read(0, 2'b00, 1'b1, 4'd5, "R8 ext after flip");
    chk_read(1, 2'b00, 1'b0, 4'd5, "R8 cur after flip");
    // R10: two ports at once on different names
    push_rd(0, 2'b10, 1'b1, 4'd8, "R10 port0 quad");
    push_rd(1, 2'b01, 1'b1, 4'd2, "R10 port1 pair");
    fire();
    // R9: read during write returns old value, then the new one
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'b00; wr_ext = 1'b0; wr_idx = 4'd3; wr_data = 64'h0000_0000_c0de_0003;
    chk_read(0, 2'b00, 1'b0, 4'd3, "R9 old before edge");
    @(posedge clk);
    refm[16 * int'(bank_mode) + 3] = 32'hc0de_0003;
    #1 wr_en = 1'b0;
    chk_read(0, 2'b00, 1'b0, 4'd3, "R9 new after edge");
    // R1: reset after activity clears everything
    do_reset();
    sweep("after reset");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule